// File: doc/BRIEF.md
# Streaming Reed-Solomon Syndrome Calculator

This block takes a received Reed-Solomon codeword one symbol per accepted clock and produces every syndrome of that codeword by the time the last symbol has gone in. Each syndrome is the received polynomial evaluated at one root of the generator polynomial. The roots are the powers of the field's primitive element alpha whose exponents are set by two elaboration-time values: a starting offset and a spacing between roots. The field width, the field polynomial, the code length and the number of check symbols are parameters, so full-length and shortened codes use the same logic.

A framing input marks the block boundaries in one of two ways, chosen by a parameter. It can be a single-cycle start marker on the first symbol, or a level that stays high over the information symbols and low over the check symbols. A clock enable freezes the whole block while it is low. When the final symbol has been taken, a one-cycle strobe says that the syndrome vector is complete, and a flag reports whether every syndrome is zero, which means that no error was detected. The next block may begin in the cycle straight after the last symbol of the previous one.

Top module: `rs_syndrome_calc`

## Requirements
- R1: Syndrome i, on `syn_o[i*SYM_W +: SYM_W]`, equals the sum over j = 0 … N_SYM−1 of r_j · β_i^(N_SYM−1−j), where r_0 is the first symbol taken, β_i = α^((ROOT_SPACE·(GEN_START+i)) mod (2^SYM_W−1)), α is the element 2 of the field built on FIELD_POLY, and i runs from 0 to N_SYM−K_SYM−1.
- R2: `syn_valid_o` goes high in the cycle after the N_SYM-th symbol of a block is taken. If `ce_i` is high in that cycle, it is low again in the next one.
- R3: `syn_zero_o` is high exactly when every syndrome is zero. A valid codeword gives all-zero syndromes, and a corrupted one does not.
- R4: In start-marker mode (SYNC_MODE = SYNC_PULSE), `sync_i` high on an enabled cycle takes `sym_i` as symbol 0 of a new block, even if a block was already in progress. The following enabled cycles take the remaining symbols whatever the level of `sync_i`.
- R5: In level mode (SYNC_MODE = SYNC_DATA_EN), an enabled cycle with `sync_i` high and no block in progress starts a block. `sync_i` is then high for the K_SYM information symbols and low for the N_SYM−K_SYM check symbols, and all N_SYM symbols are taken.
- R6: While `ce_i` is low, `sym_i` and `sync_i` are ignored, and the syndromes, the strobe and the symbol position all keep their values.
- R7: Every block takes exactly N_SYM symbols, including when N_SYM < 2^SYM_W−1 (a shortened code). Symbols presented after the N_SYM-th one without a new start have no effect.
- R8: A new block may start in the cycle right after the previous block's last symbol. Its first symbol replaces the old accumulator contents, and the previous syndromes remain readable in that cycle alongside the strobe.
- R9: With no block in progress and no start, the syndromes keep their values and the strobe stays low.
- R10: After reset, `syn_valid_o` is low and all syndromes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable; low freezes all state |
| sync_i | input | 1 | Block framing: start marker or information-symbol level, per SYNC_MODE |
| sym_i | input | SYM_W | Received symbol |
| syn_o | output | (N_SYM−K_SYM)·SYM_W | Syndrome vector, syndrome i in slice i |
| syn_valid_o | output | 1 | Syndromes of the block just finished are complete |
| syn_zero_o | output | 1 | All syndromes are zero |

## Verification
The properties assume that N_SYM is at least 2, so that two strobes can never fall in consecutive enabled cycles. They also assume that the framing input is known in every cycle after reset, because the hold checks for idle and frozen cycles depend on it. The stimulus drives every input on the falling clock edge with defined values. It meets the framing rule of each mode by producing each mode's pattern from one task per mode, and junk symbols appear only where the requirements say that they must be ignored. Expected syndromes come from direct power-sum evaluation and from a systematic encoder that the bench builds from the same roots.

// File: rtl/rs_syn_pkg.sv
`timescale 1ns/1ps
package rs_syn_pkg;

  typedef enum logic {
    SYNC_PULSE   = 1'b0,
    SYNC_DATA_EN = 1'b1
  } sync_mode_e;

  // carry-less product reduced by the field polynomial
  function automatic int gf_mul(int a, int b, int w, int poly);
    int p;
    int aa;
    p  = 0;
    aa = a;
    for (int i = 0; i < w; i++) begin
      if (((b >> i) & 1) != 0) p = p ^ aa;
      aa = aa << 1;
      if (((aa >> w) & 1) != 0) aa = aa ^ poly;
    end
    return p;
  endfunction

  function automatic int gf_alpha_pow(int e, int w, int poly);
    int r;
    r = 1;
    for (int k = 0; k < e; k++) r = gf_mul(r, 2, w, poly);
    return r;
  endfunction

  // exponent of root i, reduced early so large settings do not overflow
  function automatic int root_exp(int i, int spacing, int start, int w);
    int m;
    m = (1 << w) - 1;
    return ((spacing % m) * ((start + i) % m)) % m;
  endfunction

endpackage

// File: rtl/rs_syn_cmul.sv
`timescale 1ns/1ps
module rs_syn_cmul
  import rs_syn_pkg::*;
#(
  parameter int SYM_W      = 8,
  parameter int FIELD_POLY = 285,
  parameter int COEF       = 1
) (
  input  logic [SYM_W-1:0] a_i,
  output logic [SYM_W-1:0] p_o
);

  logic [SYM_W-1:0] col [SYM_W];

  // column j is COEF * alpha^j, fixed at elaboration
  for (genvar j = 0; j < SYM_W; j++) begin : g_col
    localparam int COL = gf_mul(COEF, 1 << j, SYM_W, FIELD_POLY);
    assign col[j] = COL[SYM_W-1:0];
  end

  always_comb begin
    p_o = '0;
    for (int j = 0; j < SYM_W; j++) begin
      if (a_i[j]) p_o = p_o ^ col[j];
    end
  end

endmodule

// File: rtl/rs_syn_cell.sv
`timescale 1ns/1ps
module rs_syn_cell #(
  parameter int SYM_W      = 8,
  parameter int FIELD_POLY = 285,
  parameter int ROOT       = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             first_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [SYM_W-1:0] acc_o
);

  logic [SYM_W-1:0] acc_q;
  logic [SYM_W-1:0] acc_scaled;

  rs_syn_cmul #(
    .SYM_W     (SYM_W),
    .FIELD_POLY(FIELD_POLY),
    .COEF      (ROOT)
  ) u_mul (
    .a_i(acc_q),
    .p_o(acc_scaled)
  );

  // Horner step; the first symbol of a block drops the old value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (take_i) begin
      acc_q <= first_i ? sym_i : (acc_scaled ^ sym_i);
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/rs_syn_ctrl.sv
`timescale 1ns/1ps
module rs_syn_ctrl
  import rs_syn_pkg::*;
#(
  parameter int         N_SYM     = 255,
  parameter sync_mode_e SYNC_MODE = SYNC_PULSE,
  localparam int        CNT_W     = $clog2(N_SYM + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic sync_i,
  output logic take_o,
  output logic first_o,
  output logic active_o,
  output logic valid_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             active_q;
  logic             valid_q;
  logic             start;
  logic             take;
  logic             last;

  if (SYNC_MODE == SYNC_PULSE) begin : g_pulse
    // a marker always restarts the block
    assign start = ce_i & sync_i;
  end else begin : g_level
    // level marks information symbols; only the first high cycle starts
    assign start = ce_i & sync_i & ~active_q;
  end

  assign take    = start | (ce_i & active_q);
  assign cnt_nxt = start ? CNT_W'(1) : (cnt_q + CNT_W'(1));
  assign last    = take & (cnt_nxt == CNT_W'(N_SYM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (take) begin
      cnt_q    <= last ? '0 : cnt_nxt;
      active_q <= ~last;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else if (ce_i) begin
      valid_q <= last;
    end
  end

  assign take_o   = take;
  assign first_o  = start;
  assign active_o = active_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/rs_syndrome_calc.sv
`timescale 1ns/1ps
module rs_syndrome_calc
  import rs_syn_pkg::*;
#(
  parameter int         SYM_W      = 8,
  parameter int         N_SYM      = 255,
  parameter int         K_SYM      = 239,
  parameter int         FIELD_POLY = 285,
  parameter int         GEN_START  = 0,
  parameter int         ROOT_SPACE = 1,
  parameter sync_mode_e SYNC_MODE  = SYNC_PULSE,
  localparam int        N_ROOT     = N_SYM - K_SYM,
  localparam int        SYN_W      = N_ROOT * SYM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             sync_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [SYN_W-1:0] syn_o,
  output logic             syn_valid_o,
  output logic             syn_zero_o
);

  logic take;
  logic first;
  logic blk_active;

  rs_syn_ctrl #(
    .N_SYM    (N_SYM),
    .SYNC_MODE(SYNC_MODE)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce_i),
    .sync_i  (sync_i),
    .take_o  (take),
    .first_o (first),
    .active_o(blk_active),
    .valid_o (syn_valid_o)
  );

  for (genvar i = 0; i < N_ROOT; i++) begin : g_root
    localparam int ROOT = gf_alpha_pow(root_exp(i, ROOT_SPACE, GEN_START, SYM_W),
                                       SYM_W, FIELD_POLY);
    rs_syn_cell #(
      .SYM_W     (SYM_W),
      .FIELD_POLY(FIELD_POLY),
      .ROOT      (ROOT)
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take),
      .first_i(first),
      .sym_i  (sym_i),
      .acc_o  (syn_o[i*SYM_W +: SYM_W])
    );
  end

  assign syn_zero_o = ~|syn_o;

endmodule

// File: rtl/rs_syndrome_calc_chk.sv
`timescale 1ns/1ps
module rs_syndrome_calc_chk #(
  parameter int SYN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_i,
  input logic             sync_i,
  input logic             active_i,
  input logic [SYN_W-1:0] syn_i,
  input logic             valid_i
);

  // R6
  ce_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(syn_i) && $stable(valid_i));

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ce_i |=> !valid_i);

  // R2
  valid_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> $past(ce_i) && $past(active_i || sync_i));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i && !sync_i |=> $stable(syn_i));

endmodule

bind rs_syndrome_calc rs_syndrome_calc_chk #(
  .SYN_W(SYN_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ce_i    (ce_i),
  .sync_i  (sync_i),
  .active_i(blk_active),
  .syn_i   (syn_o),
  .valid_i (syn_valid_o)
);

// File: tb/rs_syndrome_calc_tb_top.sv
`timescale 1ns/1ps
module rs_syndrome_calc_tb_top;

  localparam int W  = 4;
  localparam int NR = 4;
  localparam int SW = NR * W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic          ce_p = 1'b0, sync_p = 1'b0;
  logic [W-1:0]  d_p = '0;
  logic [SW-1:0] syn_p;
  logic          valid_p, zero_p;

  logic          ce_e = 1'b0, sync_e = 1'b0;
  logic [W-1:0]  d_e = '0;
  logic [SW-1:0] syn_e;
  logic          valid_e, zero_e;

  rs_syndrome_calc #(
    .SYM_W(W), .N_SYM(15), .K_SYM(11), .FIELD_POLY(19),
    .GEN_START(1), .ROOT_SPACE(2), .SYNC_MODE(rs_syn_pkg::SYNC_PULSE)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_p), .sync_i(sync_p), .sym_i(d_p),
    .syn_o(syn_p), .syn_valid_o(valid_p), .syn_zero_o(zero_p)
  );

  rs_syndrome_calc #(
    .SYM_W(W), .N_SYM(10), .K_SYM(6), .FIELD_POLY(19),
    .GEN_START(1), .ROOT_SPACE(2), .SYNC_MODE(rs_syn_pkg::SYNC_DATA_EN)
  ) dut_en_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_e), .sync_i(sync_e), .sym_i(d_e),
    .syn_o(syn_e), .syn_valid_o(valid_e), .syn_zero_o(zero_e)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] cur [15];
  int gp [5];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int gmul(int a, int b);
    int p = 0;
    for (int i = 0; i < W; i++) begin
      if (((b >> i) & 1) != 0) p ^= a;
      a = a << 1;
      if ((a & 16) != 0) a ^= 19;
    end
    return p;
  endfunction

  function automatic int gpow(int e);
    int r = 1;
    for (int k = 0; k < e; k++) r = gmul(r, 2);
    return r;
  endfunction

  // direct power-sum evaluation, roots alpha^(2*(1+i))
  function automatic logic [SW-1:0] exp_vec(int len);
    logic [SW-1:0] v = '0;
    for (int i = 0; i < NR; i++) begin
      int e = (2 * (1 + i)) % 15;
      int acc = 0;
      for (int j = 0; j < len; j++) acc ^= gmul(int'(cur[j]), gpow((e * (len - 1 - j)) % 15));
      v[i*W +: W] = acc[W-1:0];
    end
    return v;
  endfunction

  task automatic build_gen();
    gp = '{1, 0, 0, 0, 0};
    for (int i = 0; i < NR; i++) begin
      int r = gpow((2 * (1 + i)) % 15);
      for (int k = NR; k >= 1; k--) gp[k] = gp[k-1] ^ gmul(r, gp[k]);
      gp[0] = gmul(r, gp[0]);
    end
  endtask

  // systematic encode of cur[0..k-1] into cur[k..k+3]
  task automatic encode(int k);
    int rem [4] = '{0, 0, 0, 0};
    for (int j = 0; j < k; j++) begin
      int fb = int'(cur[j]) ^ rem[3];
      rem[3] = rem[2] ^ gmul(fb, gp[3]);
      rem[2] = rem[1] ^ gmul(fb, gp[2]);
      rem[1] = rem[0] ^ gmul(fb, gp[1]);
      rem[0] = gmul(fb, gp[0]);
    end
    for (int m = 0; m < 4; m++) cur[k+m] = rem[3-m][W-1:0];
  endtask

  task automatic fill(int len, int seed);
    for (int j = 0; j < len; j++) cur[j] = W'((j * 7 + seed * 3 + (j >> 1)) & 15);
  endtask

  // start-marker DUT; gap inserts two frozen cycles with a fake marker
  task automatic run_p(int len, int gap_at, bit tail);
    for (int j = 0; j < len; j++) begin
      if (j == gap_at) begin
        for (int g = 0; g < 2; g++) begin
          @(negedge clk); ce_p = 1'b0; sync_p = 1'b1; d_p = 4'hF;
        end
      end
      @(negedge clk); ce_p = 1'b1; sync_p = (j == 0); d_p = cur[j];
    end
    if (tail) begin
      @(negedge clk); ce_p = 1'b1; sync_p = 1'b0; d_p = 4'h0;
    end
  endtask

  task automatic run_e(int len, int k);
    for (int j = 0; j < len; j++) begin
      @(negedge clk); ce_e = 1'b1; sync_e = (j < k); d_e = cur[j];
    end
    @(negedge clk); ce_e = 1'b1; sync_e = 1'b0; d_e = 4'h0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(valid_p == 1'b0, "R10 valid after reset", 32'(valid_p), 0);
    chk(syn_p == '0, "R10 syndromes after reset", 32'(syn_p), 0);
    chk(zero_p == 1'b1, "R10 zero flag after reset", 32'(zero_p), 1);
    chk(valid_e == 1'b0, "R10 level-mode valid after reset", 32'(valid_e), 0);
  endtask

  task automatic t_basic();
    logic [SW-1:0] ex;
    fill(15, 1);
    ex = exp_vec(15);
    run_p(15, -1, 1'b1);
    chk(valid_p == 1'b1, "R2 strobe after last symbol", 32'(valid_p), 1);
    chk(syn_p == ex, "R1 syndromes of arbitrary block", 32'(syn_p), 32'(ex));
    chk(zero_p == (ex == '0), "R3 zero flag follows syndromes", 32'(zero_p), 32'(ex == '0));
    @(negedge clk);
    chk(valid_p == 1'b0, "R2 strobe lasts one cycle", 32'(valid_p), 0);
  endtask

  task automatic t_codeword();
    logic [SW-1:0] ex;
    fill(11, 4);
    encode(11);
    run_p(15, -1, 1'b1);
    chk(syn_p == '0, "R3 codeword gives zero syndromes", 32'(syn_p), 0);
    chk(zero_p == 1'b1, "R3 zero flag on codeword", 32'(zero_p), 1);
    cur[5] = cur[5] ^ 4'h9;
    ex = exp_vec(15);
    run_p(15, -1, 1'b1);
    chk(syn_p == ex, "R1 syndromes of corrupted codeword", 32'(syn_p), 32'(ex));
    chk(zero_p == 1'b0, "R3 zero flag low on error", 32'(zero_p), 0);
  endtask

  task automatic t_ce();
    logic [SW-1:0] ex;
    fill(15, 5);
    ex = exp_vec(15);
    run_p(15, 7, 1'b1);
    chk(syn_p == ex, "R6 frozen cycles ignored mid-block", 32'(syn_p), 32'(ex));
    ce_p = 1'b0; sync_p = 1'b1; d_p = 4'hA;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(valid_p == 1'b1, "R6 strobe held while frozen", 32'(valid_p), 1);
      chk(syn_p == ex, "R6 syndromes held while frozen", 32'(syn_p), 32'(ex));
    end
    ce_p = 1'b1; sync_p = 1'b0;
    @(negedge clk);
    chk(valid_p == 1'b0, "R2 strobe drops once enabled", 32'(valid_p), 0);
  endtask

  task automatic t_restart();
    logic [SW-1:0] ex;
    fill(15, 9);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk); ce_p = 1'b1; sync_p = (j == 0); d_p = cur[j];
    end
    fill(15, 11);
    ex = exp_vec(15);
    run_p(15, -1, 1'b1);
    chk(syn_p == ex, "R4 marker restarts block mid-way", 32'(syn_p), 32'(ex));
  endtask

  task automatic t_b2b();
    logic [SW-1:0] ex_a, ex_b;
    fill(15, 2);
    ex_a = exp_vec(15);
    run_p(15, -1, 1'b0);
    fill(15, 13);
    ex_b = exp_vec(15);
    @(negedge clk); ce_p = 1'b1; sync_p = 1'b1; d_p = cur[0];
    chk(valid_p == 1'b1, "R8 strobe with next block's first symbol", 32'(valid_p), 1);
    chk(syn_p == ex_a, "R8 previous syndromes readable", 32'(syn_p), 32'(ex_a));
    for (int j = 1; j < 15; j++) begin
      @(negedge clk); ce_p = 1'b1; sync_p = 1'b0; d_p = cur[j];
      if (j == 1) chk(valid_p == 1'b0, "R2 strobe one cycle back to back", 32'(valid_p), 0);
    end
    @(negedge clk); sync_p = 1'b0; d_p = 4'h0;
    chk(syn_p == ex_b, "R8 back-to-back block syndromes", 32'(syn_p), 32'(ex_b));
  endtask

  task automatic t_idle();
    logic [SW-1:0] held;
    held = syn_p;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk); ce_p = 1'b1; sync_p = 1'b0; d_p = W'(c + 3);
    end
    chk(syn_p == held, "R9 idle symbols ignored", 32'(syn_p), 32'(held));
    chk(valid_p == 1'b0, "R9 no strobe while idle", 32'(valid_p), 0);
  endtask

  task automatic t_level();
    logic [SW-1:0] ex, held;
    fill(6, 6);
    encode(6);
    run_e(10, 6);
    chk(valid_e == 1'b1, "R5 level-mode strobe after 10 symbols", 32'(valid_e), 1);
    chk(syn_e == '0, "R7 shortened codeword zero syndromes", 32'(syn_e), 0);
    chk(zero_e == 1'b1, "R5 zero flag on shortened codeword", 32'(zero_e), 1);
    cur[8] = cur[8] ^ 4'h3;
    ex = exp_vec(10);
    run_e(10, 6);
    chk(syn_e == ex, "R7 shortened block syndromes", 32'(syn_e), 32'(ex));
    held = syn_e;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); ce_e = 1'b1; sync_e = 1'b0; d_e = W'(c + 7);
    end
    chk(syn_e == held, "R7 symbols past block end ignored", 32'(syn_e), 32'(held));
    chk(valid_e == 1'b0, "R5 no strobe without new block", 32'(valid_e), 0);
  endtask

  initial begin
    build_gen();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_codeword();
    t_ce();
    t_restart();
    t_b2b();
    t_idle();
    t_level();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule